// File: doc/BRIEF.md
# Block Transfer Byte Sequencer

This engine moves a data transfer between a word-wide host FIFO and a byte-wide card data port. Each FIFO word carries `LANES` card bytes (two by default), packed with the earliest byte in the lowest lane. A transfer is made of a programmable number of blocks, and each block holds a programmable number of bytes. Because a word never spans two blocks, an odd block length leaves the last word of every block only partly filled. The unused upper lanes of that word are zero.

Software programs the block length and the block count through two write strobes. It then pulses `xfer_go` with the direction. The engine moves at most one byte per clock, and only while the card raises `card_rdy`. When receiving, it pauses at a word boundary while the FIFO fill is above `full_lvl`. When transmitting, it pauses while the FIFO is empty. In both cases it resumes in the first cycle after the FIFO level allows it.

When the last byte of the last block moves, the engine reloads both counters, drops `xfer_active` and sets the sticky `done_flag`. The readback outputs `len_live` and `cnt_live` show the running counters, not the programmed values.

Top module: `blkseq_engine`

## Requirements
- R1: A block-length write stores the low 11 bits of `cfg_len_wdata` plus one. It also loads the byte counter, so `len_live` shows that value in the next cycle.
- R2: A block-count write stores the low 11 bits of `cfg_cnt_wdata` plus one in the block counter (`cnt_live`). It also reloads the byte counter from the stored block length. A written value of 0x7FF gives 2048.
- R3: When receiving, bytes read from `card_rd_data` fill a word from lane 0 (bits 7:0) upward. The word is pushed (`fifo_push` with `fifo_wr_data`) in the same cycle as its last byte is read, either when the top lane fills or when the block ends. Lanes above the block's last byte are zero.
- R4: When receiving, no new word is started while `fifo_level` is greater than `full_lvl`. Reading resumes once the level has dropped to `full_lvl` or below.
- R5: When transmitting, the head word `fifo_rd_data` is sent lane 0 first, one lane per byte, while bytes remain in the block. `fifo_pop` comes with the word's last sent byte. Nothing is sent while `fifo_level` is 0.
- R6: After the last byte of a block, the block counter drops by one and the byte counter reloads the block length.
- R7: After the last byte of the last block, both counters reload, `xfer_active` falls and `done_flag` rises in the next cycle. `done_flag` stays high until `done_clr`.
- R8: At most one card strobe (`card_rd` or `card_wr`) is high per cycle, and only while `card_rdy` is high. While `card_rdy` is low nothing moves and no byte is lost.
- R9: With `xfer_active` low, no card strobe and no FIFO strobe is issued. `xfer_go` starts a transfer in direction `xfer_dir_rx` (1 = receive), and a pulse of `xfer_go` while a transfer is active is ignored.
- R10: After reset, `xfer_active` and `done_flag` are 0, and `len_live` and `cnt_live` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_go | input | 1 | Start pulse for a transfer |
| xfer_dir_rx | input | 1 | Direction sampled at start: 1 receive, 0 transmit |
| done_clr | input | 1 | Clears `done_flag` |
| cfg_len_we | input | 1 | Block-length write strobe |
| cfg_len_wdata | input | 16 | Block-length write value (low 11 bits used) |
| cfg_cnt_we | input | 1 | Block-count write strobe |
| cfg_cnt_wdata | input | 16 | Block-count write value (low 11 bits used) |
| full_lvl | input | 6 | Receive pause threshold on FIFO fill |
| fifo_level | input | 6 | Current FIFO fill in words |
| fifo_rd_data | input | 16 | Head word of the FIFO |
| fifo_pop | output | 1 | Removes the head word |
| fifo_push | output | 1 | Writes `fifo_wr_data` into the FIFO |
| fifo_wr_data | output | 16 | Packed received word |
| card_rdy | input | 1 | Card can move one byte this cycle |
| card_rd_data | input | 8 | Byte offered by the card |
| card_rd | output | 1 | Byte taken from the card this cycle |
| card_wr | output | 1 | Byte given to the card this cycle |
| card_wr_data | output | 8 | Byte sent to the card |
| xfer_active | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky end-of-transfer status |
| len_live | output | 12 | Running byte counter |
| cnt_live | output | 12 | Running block counter |

## Verification
The hardest state to reach is a receive pause that lands exactly on a block boundary. At that moment the block counter has just stepped, a fresh block is pending, and the FIFO fill is one above the threshold. The bench reaches it by setting `full_lvl` to 2 with a block length of five and no FIFO draining. The first block then yields exactly three words, and the engine must stop with `cnt_live` already decremented and `len_live` reloaded. Draining then resumes the transfer. A scoreboard checks that the half-filled final words carry zero upper lanes and that no byte is skipped across the pause.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } xfer_dir_e;

   function automatic int lane_bits(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

endpackage

// File: rtl/blkseq_counters.sv
module blkseq_counters #(
   parameter int CTR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_we,
   input  logic [CTR_W-1:0] len_val,
   input  logic             cnt_we,
   input  logic [CTR_W-1:0] cnt_val,
   input  logic             byte_step,
   output logic             byte_last,
   output logic             blk_last,
   output logic [CTR_W-1:0] byte_left,
   output logic [CTR_W-1:0] blk_left
);

   localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

   logic [CTR_W-1:0] len_q, nblk_q, bcnt_q, kcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q  <= ONE;
         nblk_q <= ONE;
         bcnt_q <= ONE;
         kcnt_q <= ONE;
      end else begin
         if (len_we) len_q <= len_val;
         if (cnt_we) nblk_q <= cnt_val;
         if (cnt_we) begin
            kcnt_q <= cnt_val;
            bcnt_q <= len_we ? len_val : len_q;
         end else if (len_we) begin
            bcnt_q <= len_val;
         end else if (byte_step) begin
            if (bcnt_q == ONE) begin
               bcnt_q <= len_q;
               if (kcnt_q == ONE) kcnt_q <= nblk_q;
               else               kcnt_q <= kcnt_q - ONE;
            end else begin
               bcnt_q <= bcnt_q - ONE;
            end
         end
      end
   end

   assign byte_last = (bcnt_q == ONE);
   assign blk_last  = (kcnt_q == ONE);
   assign byte_left = bcnt_q;
   assign blk_left  = kcnt_q;

endmodule

// File: rtl/blkseq_lane_ctl.sv
module blkseq_lane_ctl
   import blkseq_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LVL_W  = 6,
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              dir_rx_in,
   input  logic              done_clr,
   input  logic              hold,
   input  logic              card_rdy,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [LVL_W-1:0]  full_lvl,
   input  logic              byte_last,
   input  logic              blk_last,
   output logic              step,
   output logic              word_end,
   output logic [LANE_W-1:0] lane,
   output logic              active,
   output logic              dir_rx,
   output logic              done
);

   localparam logic [LANE_W-1:0] LANE_TOP = LANE_W'(LANES - 1);

   xfer_dir_e         dir_q;
   logic              active_q, done_q;
   logic [LANE_W-1:0] lane_q;
   logic              word_start, rx_ok, tx_ok, can_move, xfer_end;

   assign word_start = (lane_q == '0);
   assign rx_ok      = !word_start || (fifo_level <= full_lvl);
   assign tx_ok      = !word_start || (fifo_level != '0);
   assign can_move   = active_q && !hold && ((dir_q == DIR_RX) ? rx_ok : tx_ok);
   assign step       = can_move && card_rdy;
   assign word_end   = step && ((lane_q == LANE_TOP) || byte_last);
   assign xfer_end   = word_end && byte_last && blk_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
         dir_q    <= DIR_TX;
         lane_q   <= '0;
      end else begin
         if (xfer_end) begin
            active_q <= 1'b0;
         end else if (go && !active_q) begin
            active_q <= 1'b1;
            dir_q    <= dir_rx_in ? DIR_RX : DIR_TX;
         end
         if (xfer_end)      done_q <= 1'b1;
         else if (done_clr) done_q <= 1'b0;
         if (!active_q || hold) lane_q <= '0;
         else if (word_end)     lane_q <= '0;
         else if (step)         lane_q <= lane_q + 1'b1;
      end
   end

   assign lane   = lane_q;
   assign active = active_q;
   assign dir_rx = (dir_q == DIR_RX);
   assign done   = done_q;

endmodule

// File: rtl/blkseq_rx_pack.sv
module blkseq_rx_pack #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int LANE_W = 1,
   localparam int WORD_W = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [LANE_W-1:0] lane,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [WORD_W-1:0] word_out
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k < LANES - 1) begin : g_held
         logic [BYTE_W-1:0] acc_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             acc_q <= '0;
            else if (cap && (lane == LANE_W'(k)))   acc_q <= byte_in;
         end
         always_comb begin
            if (lane > LANE_W'(k))       word_out[k*BYTE_W +: BYTE_W] = acc_q;
            else if (lane == LANE_W'(k)) word_out[k*BYTE_W +: BYTE_W] = byte_in;
            else                         word_out[k*BYTE_W +: BYTE_W] = '0;
         end
      end else begin : g_top
         assign word_out[k*BYTE_W +: BYTE_W] = (lane == LANE_W'(k)) ? byte_in : '0;
      end
   end

endmodule

// File: rtl/blkseq_tx_unpack.sv
module blkseq_tx_unpack #(
   parameter int LANES  = 2,
   parameter int BYTE_W = 8,
   parameter int LANE_W = 1,
   localparam int WORD_W = LANES * BYTE_W
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [LANE_W-1:0] lane,
   output logic [BYTE_W-1:0] byte_out
);

   always_comb begin
      byte_out = word_in[BYTE_W-1:0];
      for (int i = 1; i < LANES; i++) begin
         if (lane == LANE_W'(i)) byte_out = word_in[i*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/blkseq_engine.sv
module blkseq_engine
   import blkseq_pkg::*;
#(
   parameter int CNT_W      = 11,
   parameter int REG_W      = 16,
   parameter int BYTE_W     = 8,
   parameter int LANES      = 2,
   parameter int FIFO_DEPTH = 32,
   localparam int WORD_W = BYTE_W * LANES,
   localparam int LVL_W  = $clog2(FIFO_DEPTH + 1),
   localparam int CTR_W  = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_go,
   input  logic              xfer_dir_rx,
   input  logic              done_clr,
   input  logic              cfg_len_we,
   input  logic [REG_W-1:0]  cfg_len_wdata,
   input  logic              cfg_cnt_we,
   input  logic [REG_W-1:0]  cfg_cnt_wdata,
   input  logic [LVL_W-1:0]  full_lvl,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic [WORD_W-1:0] fifo_rd_data,
   output logic              fifo_pop,
   output logic              fifo_push,
   output logic [WORD_W-1:0] fifo_wr_data,
   input  logic              card_rdy,
   input  logic [BYTE_W-1:0] card_rd_data,
   output logic              card_rd,
   output logic              card_wr,
   output logic [BYTE_W-1:0] card_wr_data,
   output logic              xfer_active,
   output logic              done_flag,
   output logic [CTR_W-1:0]  len_live,
   output logic [CTR_W-1:0]  cnt_live
);

   localparam int LANE_W = lane_bits(LANES);

   if (LANES < 2) begin : g_bad_lanes
      $error("blkseq_engine: LANES must be at least 2");
   end
   if (CNT_W >= REG_W) begin : g_bad_cnt
      $error("blkseq_engine: CNT_W must be narrower than REG_W");
   end
   if (BYTE_W < 1 || FIFO_DEPTH < 2) begin : g_bad_size
      $error("blkseq_engine: BYTE_W and FIFO_DEPTH out of range");
   end

   logic [CTR_W-1:0]  len_val, cnt_val;
   logic              hold, step, word_end, byte_last, blk_last, dir_rx;
   logic [LANE_W-1:0] lane;
   logic              unused_cfg_bits;

   assign len_val = CTR_W'(cfg_len_wdata[CNT_W-1:0]) + CTR_W'(1);
   assign cnt_val = CTR_W'(cfg_cnt_wdata[CNT_W-1:0]) + CTR_W'(1);
   assign hold    = cfg_len_we || cfg_cnt_we;
   assign unused_cfg_bits = ^{cfg_len_wdata[REG_W-1:CNT_W], cfg_cnt_wdata[REG_W-1:CNT_W]};

   blkseq_counters #(.CTR_W(CTR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_we    (cfg_len_we),
      .len_val   (len_val),
      .cnt_we    (cfg_cnt_we),
      .cnt_val   (cnt_val),
      .byte_step (step),
      .byte_last (byte_last),
      .blk_last  (blk_last),
      .byte_left (len_live),
      .blk_left  (cnt_live)
   );

   blkseq_lane_ctl #(.LANES(LANES), .LVL_W(LVL_W), .LANE_W(LANE_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (xfer_go),
      .dir_rx_in  (xfer_dir_rx),
      .done_clr   (done_clr),
      .hold       (hold),
      .card_rdy   (card_rdy),
      .fifo_level (fifo_level),
      .full_lvl   (full_lvl),
      .byte_last  (byte_last),
      .blk_last   (blk_last),
      .step       (step),
      .word_end   (word_end),
      .lane       (lane),
      .active     (xfer_active),
      .dir_rx     (dir_rx),
      .done       (done_flag)
   );

   blkseq_rx_pack #(.LANES(LANES), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (step && dir_rx),
      .lane     (lane),
      .byte_in  (card_rd_data),
      .word_out (fifo_wr_data)
   );

   blkseq_tx_unpack #(.LANES(LANES), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_unpack (
      .word_in  (fifo_rd_data),
      .lane     (lane),
      .byte_out (card_wr_data)
   );

   assign card_rd   = step && dir_rx;
   assign card_wr   = step && !dir_rx;
   assign fifo_push = word_end && dir_rx;
   assign fifo_pop  = word_end && !dir_rx;

endmodule

// File: rtl/blkseq_engine_chk.sv
module blkseq_engine_chk #(
   parameter int CNT_W = 11,
   parameter int REG_W = 16,
   parameter int LVL_W = 6,
   localparam int CTR_W = CNT_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_len_we,
   input logic [REG_W-1:0] cfg_len_wdata,
   input logic             cfg_cnt_we,
   input logic [REG_W-1:0] cfg_cnt_wdata,
   input logic [LVL_W-1:0] fifo_level,
   input logic             card_rdy,
   input logic             card_rd,
   input logic             card_wr,
   input logic             fifo_push,
   input logic             fifo_pop,
   input logic             xfer_active,
   input logic             done_flag,
   input logic [CTR_W-1:0] len_live,
   input logic [CTR_W-1:0] cnt_live
);

   // R8: a single byte per cycle, in one direction
   a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_rd && card_wr));

   // R8: bytes move only with the card ready
   a_r8_rdy_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rd || card_wr) |-> card_rdy);

   // R9: idle engine is silent on both sides
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |-> !(card_rd || card_wr || fifo_push || fifo_pop));

   // R3: every push carries the byte read in the same cycle
   a_r3_push_with_read: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> card_rd);

   // R5: every pop closes a byte sent in the same cycle
   a_r5_pop_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> card_wr);

   // R5: no byte is sent out of an empty FIFO
   a_r5_no_empty_send: assert property (@(posedge clk) disable iff (!rst_n)
      card_wr |-> (fifo_level != '0));

   // R7: the end of a transfer raises the status
   a_r7_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_active) |-> done_flag);

   // R1: length write loads the live byte counter
   a_r1_len_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_len_we |=> (len_live == CTR_W'($past(cfg_len_wdata[CNT_W-1:0])) + CTR_W'(1)));

   // R2: count write loads the live block counter
   a_r2_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_cnt_we |=> (cnt_live == CTR_W'($past(cfg_cnt_wdata[CNT_W-1:0])) + CTR_W'(1)));

endmodule

bind blkseq_engine blkseq_engine_chk #(.CNT_W(CNT_W), .REG_W(REG_W), .LVL_W(LVL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_len_we    (cfg_len_we),
   .cfg_len_wdata (cfg_len_wdata),
   .cfg_cnt_we    (cfg_cnt_we),
   .cfg_cnt_wdata (cfg_cnt_wdata),
   .fifo_level    (fifo_level),
   .card_rdy      (card_rdy),
   .card_rd       (card_rd),
   .card_wr       (card_wr),
   .fifo_push     (fifo_push),
   .fifo_pop      (fifo_pop),
   .xfer_active   (xfer_active),
   .done_flag     (done_flag),
   .len_live      (len_live),
   .cnt_live      (cnt_live)
);

// File: tb/blkseq_engine_bench.sv
module blkseq_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_go = 1'b0, xfer_dir_rx = 1'b0, done_clr = 1'b0;
   logic        cfg_len_we = 1'b0, cfg_cnt_we = 1'b0;
   logic [15:0] cfg_len_wdata = '0, cfg_cnt_wdata = '0;
   logic [5:0]  full_lvl = 6'd31;
   logic [5:0]  fifo_level;
   logic [15:0] fifo_rd_data, fifo_wr_data;
   logic        fifo_pop, fifo_push;
   logic        card_rdy = 1'b0;
   logic [7:0]  card_rd_data, card_wr_data;
   logic        card_rd, card_wr, xfer_active, done_flag;
   logic [11:0] len_live, cnt_live;

   always #10 clk = ~clk;

   blkseq_engine u_blkseq_engine (
      .clk(clk), .rst_n(rst_n), .xfer_go(xfer_go), .xfer_dir_rx(xfer_dir_rx),
      .done_clr(done_clr), .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
      .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_wdata(cfg_cnt_wdata), .full_lvl(full_lvl),
      .fifo_level(fifo_level), .fifo_rd_data(fifo_rd_data), .fifo_pop(fifo_pop),
      .fifo_push(fifo_push), .fifo_wr_data(fifo_wr_data), .card_rdy(card_rdy),
      .card_rd_data(card_rd_data), .card_rd(card_rd), .card_wr(card_wr),
      .card_wr_data(card_wr_data), .xfer_active(xfer_active), .done_flag(done_flag),
      .len_live(len_live), .cnt_live(cnt_live));

   // ---------------- host FIFO model ----------------
   logic [15:0] fmem [0:31];
   logic [4:0]  frp = '0, fwp = '0;
   logic [5:0]  fcnt = '0;
   logic        host_push = 1'b0, drain_en = 1'b0, host_pop;
   logic [15:0] host_wdata = '0;

   assign host_pop     = drain_en && (fcnt != 0);
   assign fifo_level   = fcnt;
   assign fifo_rd_data = fmem[frp];

   always @(posedge clk) begin
      logic do_push, do_pop;
      do_push = fifo_push || host_push;
      do_pop  = (fifo_pop || host_pop) && (fcnt != 0);
      if (do_push) begin
         fmem[fwp] <= fifo_push ? fifo_wr_data : host_wdata;
         fwp <= fwp + 1'b1;
      end
      if (do_pop) frp <= frp + 1'b1;
      fcnt <= fcnt + 6'(do_push) - 6'(do_pop);
   end

   // ---------------- card model ----------------
   int  src_idx = 0;
   int  rdy_mode = 1;   // 0 low, 1 high, 2 random
   function automatic logic [7:0] srcb(input int i);
      return 8'(i * 37 + 11);
   endfunction
   function automatic logic [15:0] wv(input int i);
      return {8'(8'h90 + i), 8'(8'h10 + 3 * i)};
   endfunction
   assign card_rd_data = srcb(src_idx);
   always @(posedge clk) begin
      if (card_rd) src_idx <= src_idx + 1;
      card_rdy <= (rdy_mode == 2) ? 1'($urandom_range(0, 1)) : (rdy_mode == 1);
   end

   // ---------------- scoreboard ----------------
   int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;
   logic [15:0] exp_words[$];
   logic [7:0]  exp_bytes[$];

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (fifo_push) begin
            if (exp_words.size() == 0) chk("R3", 1, 0, "unexpected pushed word");
            else chk("R3", fifo_wr_data, exp_words.pop_front(), "pushed word");
         end
         if (card_wr) begin
            if (exp_bytes.size() == 0) chk("R5", 1, 0, "unexpected sent byte");
            else chk("R5", card_wr_data, exp_bytes.pop_front(), "sent byte");
         end
         if (card_rd) rd_cnt++;
         if (card_wr) wr_cnt++;
      end
   end

   // ---------------- driver tasks ----------------
   task automatic tick;
      @(posedge clk); #1;
   endtask

   task automatic cfg(input int blen, input int nblk);
      tick; cfg_len_we = 1'b1; cfg_len_wdata = 16'(blen - 1);
      tick; cfg_len_we = 1'b0; cfg_cnt_we = 1'b1; cfg_cnt_wdata = 16'(nblk - 1);
      tick; cfg_cnt_we = 1'b0;
   endtask

   task automatic host_write(input logic [15:0] w);
      tick; host_push = 1'b1; host_wdata = w;
      tick; host_push = 1'b0;
   endtask

   task automatic go(input logic rx);
      tick; xfer_go = 1'b1; xfer_dir_rx = rx;
      tick; xfer_go = 1'b0;
   endtask

   task automatic expect_tx(input int blen, input int nblk, input int first);
      int wi = first;
      for (int b = 0; b < nblk; b++) begin
         int r = blen;
         while (r > 0) begin
            logic [15:0] w = wv(wi++);
            exp_bytes.push_back(w[7:0]); r--;
            if (r > 0) begin exp_bytes.push_back(w[15:8]); r--; end
         end
      end
   endtask

   task automatic expect_rx(input int blen, input int nblk);
      int si = src_idx;
      for (int b = 0; b < nblk; b++) begin
         int r = blen;
         while (r > 0) begin
            logic [7:0] lo, hi;
            lo = srcb(si++); r--; hi = 8'h00;
            if (r > 0) begin hi = srcb(si++); r--; end
            exp_words.push_back({hi, lo});
         end
      end
   endtask

   task automatic finish_xfer(input string tag, input int blen, input int nblk);
      while (!done_flag) @(negedge clk);
      chk("R7", xfer_active, 0, {tag, " active after end"});
      chk("R7", len_live, blen, {tag, " byte counter reloaded"});
      chk("R7", cnt_live, nblk, {tag, " block counter reloaded"});
      chk("R3", exp_words.size() + exp_bytes.size(), 0, {tag, " scoreboard drained"});
      repeat (3) @(negedge clk);
      chk("R7", done_flag, 1, {tag, " status sticky"});
      tick; done_clr = 1'b1; tick; done_clr = 1'b0;
      @(negedge clk);
      chk("R7", done_flag, 0, {tag, " status cleared"});
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual %0d expected %0d (transfer never ended)", 1, 0);
      summary;
      $finish;
   end

   initial begin
      int rd0, wr0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", xfer_active, 0, "active at reset");
      chk("R10", done_flag, 0, "status at reset");
      chk("R10", len_live, 1, "byte counter at reset");
      chk("R10", cnt_live, 1, "block counter at reset");

      // R1 / R2 register loads with junk upper bits
      tick; cfg_len_we = 1'b1; cfg_len_wdata = 16'hF804;
      tick; cfg_len_we = 1'b0;
      @(negedge clk);
      chk("R1", len_live, 5, "length low bits plus one");
      tick; cfg_cnt_we = 1'b1; cfg_cnt_wdata = 16'hFFFF;
      tick; cfg_cnt_we = 1'b0;
      @(negedge clk);
      chk("R2", cnt_live, 2048, "count maximum");
      chk("R2", len_live, 5, "byte counter reloaded by count write");

      // R9: inactive engine ignores a ready card and a filled FIFO
      host_write(wv(0));
      host_write(wv(1));
      wr0 = wr_cnt;
      repeat (5) @(negedge clk);
      chk("R9", wr_cnt - wr0, 0, "bytes sent while idle");
      chk("R9", fifo_level, 2, "FIFO untouched while idle");

      // R5 transmit, odd block length, random ready, go ignored mid-run
      cfg(3, 2);
      expect_tx(3, 2, 0);
      rdy_mode = 2;
      rd0 = rd_cnt;
      go(1'b0);
      go(1'b1);            // R9 second start while active
      host_write(wv(2));
      host_write(wv(3));
      finish_xfer("tx3x2", 3, 2);
      chk("R9", rd_cnt - rd0, 0, "direction kept after ignored start");
      chk("R5", fifo_level, 0, "all words popped");

      // R8 card not ready holds the engine
      rdy_mode = 0;
      cfg(2, 1);
      expect_tx(2, 1, 10);
      host_write(wv(10));
      go(1'b0);
      wr0 = wr_cnt;
      repeat (6) @(negedge clk);
      chk("R8", wr_cnt - wr0, 0, "no byte without ready");
      chk("R8", fifo_level, 1, "word kept without ready");
      rdy_mode = 1;
      finish_xfer("tx2x1", 2, 1);

      // R3 receive, even block length, draining host
      full_lvl = 6'd31;
      drain_en = 1'b1;
      rdy_mode = 2;
      cfg(4, 2);
      expect_rx(4, 2);
      go(1'b1);
      finish_xfer("rx4x2", 4, 2);

      // R4 / R6 receive pause at the almost-full threshold on a block edge
      drain_en = 1'b0;
      rdy_mode = 1;
      full_lvl = 6'd2;
      cfg(5, 3);
      expect_rx(5, 3);
      go(1'b1);
      while (fifo_level != 6'd3) @(negedge clk);
      rd0 = rd_cnt;
      repeat (10) @(negedge clk);
      chk("R4", rd_cnt - rd0, 0, "reads while above threshold");
      chk("R4", fifo_level, 3, "level held above threshold");
      chk("R6", cnt_live, 2, "block counter stepped");
      chk("R6", len_live, 5, "byte counter reloaded at block end");
      chk("R4", xfer_active, 1, "still active while paused");
      drain_en = 1'b1;
      finish_xfer("rx5x3", 5, 3);

      summary;
      $finish;
   end

endmodule